// File: doc/BRIEF.md
# Clamp On-Time Auto-Tuner

This block trims the clamp on-time of a synchronous rectifier so that the body diode of the rectifier switch conducts as briefly as possible after the switch turns off. Each rectifier cycle is measured with a duration counter. The counter is held cleared while the rectifier command is asserted. Once the command drops, the counter counts every clock in which the active-low conduction detect input reports diode conduction. On the rising edge of a cycle-end strobe, the count is latched as the measurement for that cycle.

A tuning run is started by a one-cycle request, which loads a starting clamp time and arms the loop. While armed and while clamp mode is active, each captured measurement is compared with a fixed threshold. A long conduction means the switch turned off too early, so the clamp time is raised by a fixed step. The clamp time never rises above a programmable ceiling. A short conduction ends the run and raises the done flag. The clamp time output is meant to drive a separate PWM generator, which is not part of this block.

Top module: `clamp_tuner`

## Requirements
- R1: While `cmd_in` is sampled high at a clock edge, the duration counter is zero after that edge, so a captured count only covers clocks after the command's falling edge.
- R2: While `cmd_in` is low, the counter rises by one on each clock edge at which `det_n` is sampled low. It holds on each edge at which `det_n` is high, so separate low intervals add together.
- R3: The counter saturates at its all-ones value, 2^CNT_W-1 (255 by default), and does not wrap.
- R4: On the clock edge where `cyc_end` is first sampled high after being low, `cap_count` takes the counter value from before that edge. `cap_count` does not change at any other time, so a strobe held high for several clocks captures only once.
- R5: A `tune_start` pulse sets `clamp_time` to `clamp_init`, arms the loop and clears `tune_done`. It takes effect one clock after it is sampled and has priority over an update in the same clock.
- R6: When the loop is armed and `clamp_mode` is high, a capture above THRESH (5) raises `clamp_time` by STEP (2) in the clock after the capture edge.
- R7: When the loop is armed and `clamp_mode` is high, a capture of THRESH or less leaves `clamp_time` unchanged, disarms the loop and sets `tune_done`.
- R8: While `clamp_mode` is low, captures change neither `clamp_time` nor `tune_done`, and the loop stays armed.
- R9: A raise that would exceed `clamp_max` sets `clamp_time` to `clamp_max` instead.
- R10: Each capture causes at most one clamp-time update. Once `tune_done` is set, captures cause no update until the next `tune_start`.
- R11: After reset, `clamp_time`, `cap_count` and `tune_done` are all zero and the loop is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is one count unit |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_in | input | 1 | Rectifier command; high clears the counter |
| det_n | input | 1 | Body-diode conduction detect, low while conducting |
| cyc_end | input | 1 | Cycle-end strobe; its rising edge captures the count |
| clamp_mode | input | 1 | High while the converter runs in clamp mode |
| tune_start | input | 1 | One-cycle request that starts a tuning run |
| clamp_init | input | CLAMP_W | Starting clamp time loaded by `tune_start` |
| clamp_max | input | CLAMP_W | Ceiling for the clamp time |
| clamp_time | output | CLAMP_W | Current clamp on-time value |
| cap_count | output | CNT_W | Latest captured conduction count |
| tune_done | output | 1 | Set when a run has reached the target |

## Verification
The bench sweeps the conduction length across the threshold, from 0 to 12 ticks. A comparator that is off by one (`>=` instead of `>`) would raise or stop at the wrong length. Separate tests use split detect pulses, detect held low while the command is high, and a 300-tick conduction. These catch a counter that ignores its gating or wraps to a small value. A strobe held high for four clocks catches a design that captures or updates more than once per cycle. Runs that push the clamp time against its ceiling, and captures made with clamp mode off or after the done flag is set, catch a wrapping adder and a loop that does not stop.

// File: rtl/ctune_pkg.sv
// Package: shared types for the clamp on-time tuner.
// Assumes nothing beyond standard SystemVerilog.
package ctune_pkg;

    // Decision taken by the step controller for one captured cycle.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RAISE  = 2'd1,
        ACT_FINISH = 2'd2
    } ctune_act_e;

endpackage

// File: rtl/ctune_edge.sv
// Module: ctune_edge
// Flags the clock in which the input is first seen high after being low.
// Assumes the input is already synchronous to clk.
module ctune_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);

    logic sig_q;

    // Remember the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    // A rise is "high now, low last clock".
    always_comb rise = sig_in & ~sig_q;

endmodule

// File: rtl/ctune_dur_counter.sv
// Module: ctune_dur_counter
// Gated, saturating duration counter with a capture register.
// Assumes cmd and det_n are synchronous to clk. The capture strobe is a
// one-clock pulse produced by ctune_edge.
module ctune_dur_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             det_n,
    input  logic             capture,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_count,
    output logic             cap_vld
);

    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

    // Clear while commanded on, then count conduction clocks and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd)                     cnt <= '0;
        else if (!det_n && cnt != CNT_FULL)    cnt <= cnt + 1'b1;
    end

    // Latch the count at a cycle end and flag it for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_count <= '0;
            cap_vld   <= 1'b0;
        end else begin
            cap_vld <= capture;
            if (capture) cap_count <= cnt;
        end
    end

endmodule

// File: rtl/ctune_step_ctrl.sv
// Module: ctune_step_ctrl
// Closed-loop clamp-time stepper. It raises the clamp time while the
// captured conduction is long and stops once the conduction is short.
// Assumes cap_vld is high for exactly one clock per captured cycle.
module ctune_step_ctrl
    import ctune_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CLAMP_W = 10,
    parameter int THRESH  = 5,
    parameter int STEP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tune_start,
    input  logic               clamp_mode,
    input  logic               cap_vld,
    input  logic [CNT_W-1:0]   cap_count,
    input  logic [CLAMP_W-1:0] clamp_init,
    input  logic [CLAMP_W-1:0] clamp_max,
    output logic [CLAMP_W-1:0] clamp_time,
    output logic               tune_done
);

    localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH);
    localparam logic [CLAMP_W:0] STEP_V   = (CLAMP_W+1)'(STEP);

    logic               armed;
    ctune_act_e         act;
    logic [CLAMP_W:0]   sum;
    logic [CLAMP_W-1:0] raised;

    // Decide what this clock's capture asks for.
    always_comb begin
        act = ACT_NONE;
        if (cap_vld && armed && clamp_mode)
            act = (cap_count > THRESH_V) ? ACT_RAISE : ACT_FINISH;
    end

    // Add one step with a carry bit and clamp the result to the ceiling.
    always_comb begin
        sum    = {1'b0, clamp_time} + STEP_V;
        raised = (sum > {1'b0, clamp_max}) ? clamp_max : sum[CLAMP_W-1:0];
    end

    // Apply a start request or the decision for the latest capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_time <= '0;
            armed      <= 1'b0;
            tune_done  <= 1'b0;
        end else if (tune_start) begin
            clamp_time <= clamp_init;
            armed      <= 1'b1;
            tune_done  <= 1'b0;
        end else begin
            case (act)
                ACT_RAISE:  clamp_time <= raised;
                ACT_FINISH: begin
                    armed     <= 1'b0;
                    tune_done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/clamp_tuner.sv
// Module: clamp_tuner (top)
// Measures body-diode conduction after each rectifier command and tunes
// the clamp on-time until the conduction is within the threshold.
// Assumes all inputs are synchronous to clk and one clock is one tick.
module clamp_tuner #(
    parameter int CNT_W   = 8,
    parameter int CLAMP_W = 10,
    parameter int THRESH  = 5,
    parameter int STEP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_in,
    input  logic               det_n,
    input  logic               cyc_end,
    input  logic               clamp_mode,
    input  logic               tune_start,
    input  logic [CLAMP_W-1:0] clamp_init,
    input  logic [CLAMP_W-1:0] clamp_max,
    output logic [CLAMP_W-1:0] clamp_time,
    output logic [CNT_W-1:0]   cap_count,
    output logic               tune_done
);

    logic             end_rise;
    logic [CNT_W-1:0] dur_cnt;
    logic             cap_vld;

    // Cycle-end edge detection.
    ctune_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (cyc_end),
        .rise   (end_rise)
    );

    // Conduction measurement.
    ctune_dur_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_in),
        .det_n     (det_n),
        .capture   (end_rise),
        .cnt       (dur_cnt),
        .cap_count (cap_count),
        .cap_vld   (cap_vld)
    );

    // Clamp-time loop.
    ctune_step_ctrl #(
        .CNT_W   (CNT_W),
        .CLAMP_W (CLAMP_W),
        .THRESH  (THRESH),
        .STEP    (STEP)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_start (tune_start),
        .clamp_mode (clamp_mode),
        .cap_vld    (cap_vld),
        .cap_count  (cap_count),
        .clamp_init (clamp_init),
        .clamp_max  (clamp_max),
        .clamp_time (clamp_time),
        .tune_done  (tune_done)
    );

endmodule

// File: rtl/ctune_chk.sv
// Module: ctune_chk
// Temporal checks for clamp_tuner, attached with bind.
// Assumes synchronous active-low reset on rst_n.
module ctune_chk #(
    parameter int CNT_W   = 8,
    parameter int CLAMP_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_in,
    input logic               det_n,
    input logic               cyc_end,
    input logic               clamp_mode,
    input logic               tune_start,
    input logic [CLAMP_W-1:0] clamp_time,
    input logic [CNT_W-1:0]   cap_count,
    input logic               tune_done,
    input logic [CNT_W-1:0]   dur_cnt,
    input logic               cap_vld
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_in |=> dur_cnt == '0); // R1
    AST_CNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_in && det_n) |=> dur_cnt == $past(dur_cnt)); // R2
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_in && dur_cnt == FULL) |=> dur_cnt == FULL); // R3
    AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(cap_count)); // R4
    AST_NO_UPDATE_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!clamp_mode && !tune_start) |=> ($stable(clamp_time) && $stable(tune_done))); // R8
    AST_UPDATE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_vld && !tune_start) |=> $stable(clamp_time)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_done && !tune_start) |=> (tune_done && $stable(clamp_time))); // R10

endmodule

bind clamp_tuner ctune_chk #(.CNT_W(CNT_W), .CLAMP_W(CLAMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_in     (cmd_in),
    .det_n      (det_n),
    .cyc_end    (cyc_end),
    .clamp_mode (clamp_mode),
    .tune_start (tune_start),
    .clamp_time (clamp_time),
    .cap_count  (cap_count),
    .tune_done  (tune_done),
    .dur_cnt    (dur_cnt),
    .cap_vld    (cap_vld)
);

// File: tb/tb_clamp_tuner.sv
// Bench: tb_clamp_tuner. Sweeps conduction lengths and checks the clamp
// loop against values worked out arithmetically from the requirements.
module tb_clamp_tuner;

    localparam int CNT_W   = 8;
    localparam int CLAMP_W = 10;
    localparam int THRESH  = 5;
    localparam int STEP    = 2;
    localparam int FULL    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_in = 1'b1;
    logic               det_n = 1'b1;
    logic               cyc_end = 1'b0;
    logic               clamp_mode = 1'b1;
    logic               tune_start = 1'b0;
    logic [CLAMP_W-1:0] clamp_init = '0;
    logic [CLAMP_W-1:0] clamp_max = '1;
    logic [CLAMP_W-1:0] clamp_time;
    logic [CNT_W-1:0]   cap_count;
    logic               tune_done;

    int errors = 0;
    int checks = 0;

    clamp_tuner #(.CNT_W(CNT_W), .CLAMP_W(CLAMP_W), .THRESH(THRESH), .STEP(STEP)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_in     (cmd_in),
        .det_n      (det_n),
        .cyc_end    (cyc_end),
        .clamp_mode (clamp_mode),
        .tune_start (tune_start),
        .clamp_init (clamp_init),
        .clamp_max  (clamp_max),
        .clamp_time (clamp_time),
        .cap_count  (cap_count),
        .tune_done  (tune_done)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Compare one value and record the outcome.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arm a run from a given start value.
    task automatic start_run(input int init);
        @(negedge clk);
        clamp_init = CLAMP_W'(init);
        tune_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
    endtask

    // One rectifier cycle: detect low for a ticks, high for gap, low for c,
    // then a cycle-end strobe held for hold clocks. Returns at a negedge
    // after the clamp update has settled.
    task automatic run_cycle(input int a, input int gap, input int c,
                             input int hold, input bit det_during_cmd);
        cmd_in = 1'b1;
        det_n  = det_during_cmd ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
        cmd_in = 1'b0;
        det_n  = 1'b0;
        repeat (a) @(negedge clk);
        det_n = 1'b1;
        repeat (gap) @(negedge clk);
        det_n = 1'b0;
        repeat (c) @(negedge clk);
        det_n   = (hold > 1) ? 1'b0 : 1'b1;
        cyc_end = 1'b1;
        repeat (hold) @(negedge clk);
        cyc_end = 1'b0;
        det_n   = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11 clamp_time", int'(clamp_time), 0);
        check("R11 cap_count", int'(cap_count), 0);
        check("R11 tune_done", int'(tune_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: loop disarmed, so a long capture changes nothing.
        run_cycle(10, 0, 0, 1, 1'b0);
        check("R11 disarmed clamp", int'(clamp_time), 0);
        check("R11 disarmed done", int'(tune_done), 0);

        // R6/R7 sweep across the threshold, with R5 start each time.
        for (int len = 0; len <= 12; len++) begin
            start_run(100);
            check("R5 load", int'(clamp_time), 100);
            check("R5 done cleared", int'(tune_done), 0);
            run_cycle(len, 0, 0, 1, 1'b0);
            check("R4 capture", int'(cap_count), len);
            if (len > THRESH) begin
                check("R6 raise", int'(clamp_time), 100 + STEP);
                check("R6 not done", int'(tune_done), 0);
            end else begin
                check("R7 hold", int'(clamp_time), 100);
                check("R7 done", int'(tune_done), 1);
            end
        end

        // R1: detect low during the command is not counted.
        start_run(200);
        run_cycle(7, 0, 0, 1, 1'b1);
        check("R1 cleared while cmd", int'(cap_count), 7);
        // R2: split conduction intervals add up.
        run_cycle(2, 3, 4, 1, 1'b0);
        check("R2 split sum", int'(cap_count), 6);
        check("R2 raise count", int'(clamp_time), 200 + 2 * STEP);
        // R3: long conduction saturates.
        run_cycle(300, 0, 0, 1, 1'b0);
        check("R3 saturate", int'(cap_count), FULL);

        // R4/R10: strobe held high captures and updates once.
        start_run(300);
        run_cycle(9, 0, 0, 4, 1'b0);
        check("R4 single capture", int'(cap_count), 9);
        check("R10 single update", int'(clamp_time), 300 + STEP);

        // R8: clamp mode off, no update, loop stays armed.
        clamp_mode = 1'b0;
        run_cycle(3, 0, 0, 1, 1'b0);
        check("R8 clamp frozen", int'(clamp_time), 300 + STEP);
        check("R8 done frozen", int'(tune_done), 0);
        clamp_mode = 1'b1;
        run_cycle(8, 0, 0, 1, 1'b0);
        check("R8 still armed", int'(clamp_time), 300 + 2 * STEP);

        // R9: ceiling at 105 from 100.
        clamp_max = CLAMP_W'(105);
        start_run(100);
        for (int k = 0; k < 4; k++) begin
            run_cycle(10, 0, 0, 1, 1'b0);
            check("R9 ceiling", int'(clamp_time), (100 + STEP * (k + 1) > 105) ? 105 : 100 + STEP * (k + 1));
        end
        // R9 at the top of the range: no wrap.
        clamp_max = '1;
        start_run(1022);
        run_cycle(10, 0, 0, 1, 1'b0);
        check("R9 top no wrap", int'(clamp_time), 1023);

        // R10: after done, long captures cause no update.
        start_run(50);
        run_cycle(2, 0, 0, 1, 1'b0);
        check("R7 finish", int'(tune_done), 1);
        run_cycle(20, 0, 0, 1, 1'b0);
        check("R10 no update after done", int'(clamp_time), 50);
        check("R10 done kept", int'(tune_done), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule